// File: doc/BRIEF.md
# MII Carrier Sense, Collision and Isolate Gate

This block sits between the per-channel receive and transmit datapaths of a multi-channel 10/100 Ethernet transceiver and the media-independent interface (MII) pins. For every channel it produces the carrier-sense and collision status signals. It uses a transmit-activity indication and a receive-activity indication, together with that channel's duplex and repeater mode settings.

The block also applies isolation to each channel. An isolated channel ignores its transmit enable, transmit error and transmit nibble inputs. The outputs it would otherwise drive get their enables withdrawn, one enable per output group, so the pad ring can float them. Each channel keeps its isolate state in a register. That register loads a strap value during reset and afterwards takes writes from the management side. Its value can always be read back, so management access keeps working while a channel is isolated.

Top module: `mii_status_gate`

## Requirements
- R1: While reset is held, the isolate state of each channel loads that channel's strap bit (bit n of `iso_strap` for channel n). Carrier sense and collision are low after reset.
- R2: With half duplex, no repeater mode and the channel not isolated, `crs` for that channel goes high one clock after a cycle in which the transmit enable or the receive activity input was high. It goes low one clock after both were low.
- R3: In full-duplex mode or repeater mode, `crs` one clock later equals the receive activity input alone, whatever the transmit enable is.
- R4: In half duplex with the channel not isolated, `col` goes high one clock after a cycle in which transmit enable and receive activity were both high, and is low otherwise. This applies with or without repeater mode.
- R5: In full-duplex mode, `col` stays low whatever the activity inputs are.
- R6: While a channel is isolated, its forwarded transmit enable, transmit error and transmit nibble are all zero. Its transmit enable does not contribute to `crs` or `col`.
- R7: While a channel is isolated, its receive-group, status-group and clock-group output enables are low. While it is not isolated, all three are high.
- R8: A management write (`iso_wr` bit n high) loads `iso_wdata` bit n into channel n's isolate state at the next clock, and `iso_stat` reports that state at all times, including while the channel is isolated.
- R9: While a channel is not isolated, its receive nibble, receive data valid and receive error outputs equal the core's receive signals in the same cycle. Its forwarded transmit signals equal the transmit inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| iso_strap | input | NCH | Reset value of each channel's isolate state |
| iso_wr | input | NCH | Per-channel management write strobe for the isolate state |
| iso_wdata | input | NCH | Isolate value written when the strobe is high |
| full_dup | input | NCH | 1 = full duplex, per channel |
| rptr_mode | input | NCH | 1 = repeater mode, per channel |
| tx_en_i | input | NCH | Transmit enable from the MAC, per channel |
| tx_er_i | input | NCH | Transmit error from the MAC, per channel |
| txd_i | input | NCH*DW | Transmit nibbles from the MAC, channel n at bits n*DW+: DW |
| rx_act | input | NCH | Receive activity from the line detector, per channel |
| rxd_core | input | NCH*DW | Receive nibbles from the core |
| rx_dv_core | input | NCH | Receive data valid from the core |
| rx_er_core | input | NCH | Receive error from the core |
| tx_en_o | output | NCH | Gated transmit enable to the core |
| tx_er_o | output | NCH | Gated transmit error to the core |
| txd_o | output | NCH*DW | Gated transmit nibbles to the core |
| rxd_o | output | NCH*DW | Receive nibbles toward the MII |
| rx_dv_o | output | NCH | Receive data valid toward the MII |
| rx_er_o | output | NCH | Receive error toward the MII |
| crs_o | output | NCH | Carrier sense, registered |
| col_o | output | NCH | Collision, registered |
| rx_oe | output | NCH | Output enable of the receive group |
| stat_oe | output | NCH | Output enable of the carrier/collision group |
| clk_oe | output | NCH | Output enable of the transmit and receive clock pins |
| iso_stat | output | NCH | Current isolate state, for management readback |

## Verification
Suppose a channel's isolate register held the wrong value. The three output enables of that channel and `iso_stat` would show it in the very first cycle after the faulty update. The forwarded transmit signals would show it in the same cycle, as soon as the transmit enable is driven. A wrong mode decode or a wrong activity combination only appears in `crs` or `col`. It shows one clock after the input pattern that should have produced the other value. So every combination of duplex, repeater, transmit and receive activity is driven on each channel in turn, with the other channels held quiet so that crosstalk between channels is also visible.

// File: rtl/mii_stat_pkg.sv
package mii_stat_pkg;

  // Carrier sense: receive activity always counts; transmit activity only
  // counts in plain half-duplex operation.
  function automatic logic carrier_f(input logic tx, input logic rx,
                                     input logic fd, input logic rp);
    return rx | (tx & ~fd & ~rp);
  endfunction

  // Collision: simultaneous transmit and receive, never in full duplex.
  function automatic logic collide_f(input logic tx, input logic rx,
                                     input logic fd);
    return tx & rx & ~fd;
  endfunction

endpackage

// File: rtl/iso_ctl.sv
module iso_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic strap,
  input  logic wr,
  input  logic wdata,
  output logic iso
);

  always_ff @(posedge clk) begin
    if (!rst_n)   iso <= strap;
    else if (wr)  iso <= wdata;
  end

  // R8: a write lands one clock later
  a_r8_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> iso == $past(wdata));

  // R8: no write, no change
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(iso));

endmodule

// File: rtl/chan_status.sv
module chan_status
  import mii_stat_pkg::*;
#(
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          iso,
  input  logic          fd,
  input  logic          rp,
  input  logic          tx_en_i,
  input  logic          tx_er_i,
  input  logic [DW-1:0] txd_i,
  input  logic          rx_act,
  output logic          tx_en_o,
  output logic          tx_er_o,
  output logic [DW-1:0] txd_o,
  output logic          crs_o,
  output logic          col_o
);

  logic tx_live;   // transmit activity after isolate gating
  logic crs_nxt;
  logic col_nxt;
  logic past_ok;

  always_comb begin
    tx_live = tx_en_i & ~iso;
    tx_en_o = tx_live;
    tx_er_o = tx_er_i & ~iso;
    txd_o   = iso ? '0 : txd_i;
    crs_nxt = carrier_f(tx_live, rx_act, fd, rp);
    col_nxt = collide_f(tx_live, rx_act, fd);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crs_o   <= 1'b0;
      col_o   <= 1'b0;
      past_ok <= 1'b0;
    end else begin
      crs_o   <= crs_nxt;
      col_o   <= col_nxt;
      past_ok <= 1'b1;
    end
  end

  a_r2_crs_half: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(iso) && !$past(fd) && !$past(rp))
      |-> crs_o == ($past(tx_en_i) | $past(rx_act)));

  a_r3_crs_rx_only: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && ($past(fd) || $past(rp))) |-> crs_o == $past(rx_act));

  a_r4_col_half: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(fd) && !$past(iso))
      |-> col_o == ($past(tx_en_i) & $past(rx_act)));

  a_r5_col_fd: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(fd)) |-> !col_o);

  a_r6_tx_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    iso |-> (!tx_en_o && !tx_er_o && txd_o == '0));

  a_r6_iso_no_tx_col: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(iso)) |-> (col_o == 1'b0 && crs_o == $past(rx_act)));

endmodule

// File: rtl/rx_drive.sv
module rx_drive #(
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          iso,
  input  logic [DW-1:0] rxd_i,
  input  logic          rx_dv_i,
  input  logic          rx_er_i,
  output logic [DW-1:0] rxd_o,
  output logic          rx_dv_o,
  output logic          rx_er_o,
  output logic          rx_oe,
  output logic          stat_oe,
  output logic          clk_oe
);

  logic drive_en;

  always_comb begin
    drive_en = ~iso;
    rx_oe    = drive_en;
    stat_oe  = drive_en;
    clk_oe   = drive_en;
    rxd_o    = rxd_i;
    rx_dv_o  = rx_dv_i;
    rx_er_o  = rx_er_i;
  end

  a_r7_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
    iso |-> (!rx_oe && !stat_oe && !clk_oe));

  a_r7_oe_on: assert property (@(posedge clk) disable iff (!rst_n)
    !iso |-> (rx_oe && stat_oe && clk_oe));

  a_r9_rx_pass: assert property (@(posedge clk) disable iff (!rst_n)
    !iso |-> (rxd_o == rxd_i && rx_dv_o == rx_dv_i && rx_er_o == rx_er_i));

endmodule

// File: rtl/mii_status_gate.sv
module mii_status_gate #(
  parameter int NCH = 4,
  parameter int DW  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    iso_strap,
  input  logic [NCH-1:0]    iso_wr,
  input  logic [NCH-1:0]    iso_wdata,
  input  logic [NCH-1:0]    full_dup,
  input  logic [NCH-1:0]    rptr_mode,
  input  logic [NCH-1:0]    tx_en_i,
  input  logic [NCH-1:0]    tx_er_i,
  input  logic [NCH*DW-1:0] txd_i,
  input  logic [NCH-1:0]    rx_act,
  input  logic [NCH*DW-1:0] rxd_core,
  input  logic [NCH-1:0]    rx_dv_core,
  input  logic [NCH-1:0]    rx_er_core,
  output logic [NCH-1:0]    tx_en_o,
  output logic [NCH-1:0]    tx_er_o,
  output logic [NCH*DW-1:0] txd_o,
  output logic [NCH*DW-1:0] rxd_o,
  output logic [NCH-1:0]    rx_dv_o,
  output logic [NCH-1:0]    rx_er_o,
  output logic [NCH-1:0]    crs_o,
  output logic [NCH-1:0]    col_o,
  output logic [NCH-1:0]    rx_oe,
  output logic [NCH-1:0]    stat_oe,
  output logic [NCH-1:0]    clk_oe,
  output logic [NCH-1:0]    iso_stat
);

  logic [NCH-1:0] iso_q;

  assign iso_stat = iso_q;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    localparam int LO = ch * DW;

    iso_ctl u_iso (
      .clk   (clk),
      .rst_n (rst_n),
      .strap (iso_strap[ch]),
      .wr    (iso_wr[ch]),
      .wdata (iso_wdata[ch]),
      .iso   (iso_q[ch])
    );

    chan_status #(.DW(DW)) u_stat (
      .clk     (clk),
      .rst_n   (rst_n),
      .iso     (iso_q[ch]),
      .fd      (full_dup[ch]),
      .rp      (rptr_mode[ch]),
      .tx_en_i (tx_en_i[ch]),
      .tx_er_i (tx_er_i[ch]),
      .txd_i   (txd_i[LO +: DW]),
      .rx_act  (rx_act[ch]),
      .tx_en_o (tx_en_o[ch]),
      .tx_er_o (tx_er_o[ch]),
      .txd_o   (txd_o[LO +: DW]),
      .crs_o   (crs_o[ch]),
      .col_o   (col_o[ch])
    );

    rx_drive #(.DW(DW)) u_rx (
      .clk     (clk),
      .rst_n   (rst_n),
      .iso     (iso_q[ch]),
      .rxd_i   (rxd_core[LO +: DW]),
      .rx_dv_i (rx_dv_core[ch]),
      .rx_er_i (rx_er_core[ch]),
      .rxd_o   (rxd_o[LO +: DW]),
      .rx_dv_o (rx_dv_o[ch]),
      .rx_er_o (rx_er_o[ch]),
      .rx_oe   (rx_oe[ch]),
      .stat_oe (stat_oe[ch]),
      .clk_oe  (clk_oe[ch])
    );
  end

  // R1: status is quiet in the first cycle after reset
  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst_n;

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_d) |-> (crs_o == '0 && col_o == '0));

endmodule

// File: tb/mii_status_gate_test.sv
module mii_status_gate_test;

  localparam int NCH = 4;
  localparam int DW  = 4;
  localparam int CLK_PERIOD = 10;

  // vector: {fd, rp, tx, rx, exp_crs, exp_col}
  localparam logic [5:0] VEC [16] = '{
    6'b0000_00, 6'b0001_10, 6'b0010_10, 6'b0011_11,
    6'b0100_00, 6'b0101_10, 6'b0110_00, 6'b0111_11,
    6'b1000_00, 6'b1001_10, 6'b1010_00, 6'b1011_10,
    6'b1100_00, 6'b1101_10, 6'b1110_00, 6'b1111_10
  };

  logic clk = 1'b0;
  logic rst_n;
  logic [NCH-1:0]    iso_strap, iso_wr, iso_wdata, full_dup, rptr_mode;
  logic [NCH-1:0]    tx_en_i, tx_er_i, rx_act, rx_dv_core, rx_er_core;
  logic [NCH*DW-1:0] txd_i, rxd_core;
  logic [NCH-1:0]    tx_en_o, tx_er_o, rx_dv_o, rx_er_o, crs_o, col_o;
  logic [NCH-1:0]    rx_oe, stat_oe, clk_oe, iso_stat;
  logic [NCH*DW-1:0] txd_o, rxd_o;

  int n_vec = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mii_status_gate #(.NCH(NCH), .DW(DW)) uut (.*);

  task automatic check(input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    full_dup = '0; rptr_mode = '0; tx_en_i = '0; tx_er_i = '0;
    rx_act = '0; txd_i = '0; rxd_core = '0; rx_dv_core = '0;
    rx_er_core = '0; iso_wr = '0; iso_wdata = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_err++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    idle();
    rst_n = 1'b0;
    iso_strap = 4'b0101;
    repeat (3) @(posedge clk);
    #1;
    // R1: strap loaded, status low, enables follow isolate
    check("R1 iso_stat", 64'(iso_stat), 64'h5);
    check("R1 crs", 64'(crs_o), 64'h0);
    check("R1 col", 64'(col_o), 64'h0);
    check("R7 rx_oe strap", 64'(rx_oe), 64'hA);
    @(negedge clk);
    rst_n = 1'b1;
    // R8: clear all isolate bits
    iso_wr = '1; iso_wdata = '0;
    @(posedge clk); #1;
    check("R8 write clear", 64'(iso_stat), 64'h0);
    check("R7 oe on", 64'({rx_oe, stat_oe, clk_oe}), 64'hFFF);
    @(negedge clk); iso_wr = '0;

    // truth-table walk, one channel at a time (R2 R3 R4 R5)
    for (int ch = 0; ch < NCH; ch++) begin
      for (int i = 0; i < 16; i++) begin
        @(negedge clk);
        idle();
        full_dup[ch]  = VEC[i][5];
        rptr_mode[ch] = VEC[i][4];
        tx_en_i[ch]   = VEC[i][3];
        rx_act[ch]    = VEC[i][2];
        @(posedge clk); #1;
        check("R2/R3 crs vector", 64'(crs_o), 64'(VEC[i][1]) << ch);
        check("R4/R5 col vector", 64'(col_o), 64'(VEC[i][0]) << ch);
      end
    end

    // R9: pass-through when not isolated
    @(negedge clk);
    idle();
    rxd_core = 16'hA5C3; rx_dv_core = 4'b1010; rx_er_core = 4'b0110;
    txd_i = 16'h3C5A; tx_er_i = 4'b1001; tx_en_i = 4'b0011;
    #1;
    check("R9 rxd", 64'(rxd_o), 64'hA5C3);
    check("R9 dv/er", 64'({rx_dv_o, rx_er_o}), 64'hA6);
    check("R9 txd", 64'(txd_o), 64'h3C5A);
    check("R9 tx en/er", 64'({tx_en_o, tx_er_o}), 64'h39);

    // R8 R6 R7: isolate channel 2 by write
    @(negedge clk);
    idle();
    iso_wr = 4'b0100; iso_wdata = 4'b0100;
    @(posedge clk); #1;
    check("R8 iso ch2", 64'(iso_stat), 64'h4);
    @(negedge clk);
    iso_wr = '0;
    tx_en_i = 4'b0100; tx_er_i = 4'b0100; txd_i = 16'h0F00; rx_act = 4'b0000;
    #1;
    check("R6 tx gated", 64'({tx_en_o, tx_er_o, txd_o}), 64'h0);
    check("R7 oe ch2 off", 64'({rx_oe, stat_oe, clk_oe}), 64'hBBB);
    @(posedge clk); #1;
    check("R6 crs ignores tx", 64'(crs_o), 64'h0);
    @(negedge clk);
    rx_act = 4'b0100;
    @(posedge clk); #1;
    check("R6 col ignores tx", 64'(col_o), 64'h0);
    check("R6 crs from rx", 64'(crs_o), 64'h4);
    check("R8 readback isolated", 64'(iso_stat), 64'h4);

    // R8 R7: release isolate, enables return, transmit counts again
    @(negedge clk);
    iso_wr = 4'b0100; iso_wdata = 4'b0000;
    @(posedge clk); #1;
    check("R7 oe restored", 64'({rx_oe, stat_oe, clk_oe}), 64'hFFF);
    check("R9 tx restored", 64'(tx_en_o), 64'h4);
    @(negedge clk); iso_wr = '0;
    @(posedge clk); #1;
    check("R4 col after release", 64'(col_o), 64'h4);

    // R1: reset again with other strap
    @(negedge clk);
    idle(); rst_n = 1'b0; iso_strap = 4'b1000; tx_en_i = '1; rx_act = '1;
    @(posedge clk); #1;
    check("R1 strap reload", 64'(iso_stat), 64'h8);
    check("R1 status reset", 64'({crs_o, col_o}), 64'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

endmodule